// File: doc/BRIEF.md
# FIFO Occupancy Threshold Interrupt Block

This block sits beside three FIFOs of a network controller: a transmit payload FIFO, a transmit completion-status FIFO and a receive status FIFO. It turns their occupancy counts into interrupt events. Software programs one threshold per FIFO through a 32-bit register port. For the transmit payload FIFO the threshold is counted in 64-byte blocks, and the event fires when the free space is larger than that. For the two status FIFOs the threshold is counted in 32-bit words, and the event fires when the used space is larger than it. Separate events report a full status FIFO and a single-cycle receive-drop pulse.

Each event sets a sticky status bit on the rising edge of its condition. Software clears a bit by writing 1 to it. A per-bit enable register masks the bits into a single registered interrupt line. A constant read-only pattern register lets software check the byte ordering of its bus path.

Top module: `fifo_lvl_irq`

## Requirements
- R1: After reset, the threshold register reads 0x48000000, the enable and status registers read 0, and `irq` is low.
- R2: Address 3 always reads 0x87654321, and writes to it change nothing.
- R3: The threshold register (address 0) holds the payload threshold in bits 31:24, the transmit-status threshold in bits 23:16 and the receive-status threshold in bits 7:0. Bits 15:8 read 0 and ignore writes.
- R4: Status bit 9 sets when the payload free count in bytes becomes strictly greater than 64 times bits 31:24. Equality does not set it.
- R5: Status bit 7 sets when the transmit-status used count becomes strictly greater than bits 23:16. Status bit 3 does the same for the receive-status count against bits 7:0.
- R6: Status bit 8 sets when the transmit-status used count equals its depth. Status bit 4 sets when the receive-status used count equals its depth.
- R7: A one-cycle pulse on `rx_drop` sets status bit 6.
- R8: The status register (address 2) is sticky. A bit stays set after its condition goes away. Writing 1 to a bit clears it, and writing 0 to a bit has no effect.
- R9: If a status bit is cleared while its condition is still true, it reads 0 for one cycle and is set again on the next cycle.
- R10: The enable register (address 1) implements only bits 9, 8, 7, 6, 4 and 3; all other bits read 0. One cycle after the status bits update, `irq` equals the OR of the status bits that are also enabled.
- R11: `rdata` is registered. It presents the addressed register one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 threshold, 1 enable, 2 status, 3 pattern |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| txd_free | input | TXD_W | Free bytes in the transmit payload FIFO |
| txs_used | input | TXS_W | Used words in the transmit-status FIFO |
| rxs_used | input | RXS_W | Used words in the receive-status FIFO |
| rx_drop | input | 1 | Single-cycle receive-drop event |
| irq | output | 1 | Registered combined interrupt |

## Verification
The payload threshold is driven to exactly 64 times its setting and then to one byte more. This separates a strict comparison from greater-or-equal, and it shows that the block-to-byte scaling is applied. The status thresholds are driven one word below, at and above their settings, and then to the full depth. The full case must raise the full bit and the level bit together, which separates the depth-equality test from the threshold test. Clearing a bit while its condition still holds, and reading the register twice in a row, shows the one-cycle gap and then the re-set. Enable patterns that cover, mask and then uncover a pending bit show that `irq` follows the masked OR and not the raw status.

// File: rtl/fli_pkg.sv
package fli_pkg;
  localparam int NB = 10;
  localparam logic [NB-1:0] IRQ_MASK = 10'h3D8;
  localparam int B_TXDA = 9;
  localparam int B_TXSF = 8;
  localparam int B_TXSL = 7;
  localparam int B_RXDR = 6;
  localparam int B_RXSF = 4;
  localparam int B_RXSL = 3;
  localparam logic [1:0] A_LVL  = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_BYTE = 2'd3;
  localparam logic [31:0] LVL_RST   = 32'h4800_0000;
  localparam logic [31:0] LVL_WMASK = 32'hFFFF_00FF;
  localparam logic [31:0] BYTE_PAT  = 32'h8765_4321;
endpackage

// File: rtl/fli_cond.sv
module fli_cond import fli_pkg::*; #(
  parameter int TXD_W = 16,
  parameter int TXS_DEPTH = 128,
  parameter int RXS_DEPTH = 128,
  localparam int TXS_W = $clog2(TXS_DEPTH + 1),
  localparam int RXS_W = $clog2(RXS_DEPTH + 1)
) (
  input  logic [31:0]      lvl,
  input  logic [TXD_W-1:0] txd_free,
  input  logic [TXS_W-1:0] txs_used,
  input  logic [RXS_W-1:0] rxs_used,
  input  logic             rx_drop,
  output logic [NB-1:0]    cond
);
  // payload free bytes against a threshold counted in 64-byte blocks
  function automatic logic above_blocks(input logic [TXD_W-1:0] free_b, input logic [7:0] blocks);
    return 32'(free_b) > (32'(blocks) << 6);
  endfunction

  function automatic logic above_words(input logic [15:0] used, input logic [7:0] words);
    return used > 16'(words);
  endfunction

  always_comb begin
    cond = '0;
    cond[B_TXDA] = above_blocks(txd_free, lvl[31:24]);
    cond[B_TXSL] = above_words(16'(txs_used), lvl[23:16]);
    cond[B_RXSL] = above_words(16'(rxs_used), lvl[7:0]);
    cond[B_TXSF] = (32'(txs_used) == 32'(TXS_DEPTH));
    cond[B_RXSF] = (32'(rxs_used) == 32'(RXS_DEPTH));
    cond[B_RXDR] = rx_drop;
  end
endmodule

// File: rtl/fli_sticky.sv
module fli_sticky #(
  parameter int N = 10,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  output logic [N-1:0] rise,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      logic prev_q, stat_q;
      assign rise[i] = cond[i] & ~prev_q;
      assign stat[i] = stat_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          stat_q <= 1'b0;
        end else begin
          // forgetting the history on a clear makes a held condition re-arm
          prev_q <= clr[i] ? 1'b0 : cond[i];
          stat_q <= (stat_q & ~clr[i]) | rise[i];
        end
      end
    end else begin : g_tie
      assign rise[i] = 1'b0;
      assign stat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq import fli_pkg::*; #(
  parameter int TXD_W = 16,
  parameter int TXS_DEPTH = 128,
  parameter int RXS_DEPTH = 128,
  localparam int TXS_W = $clog2(TXS_DEPTH + 1),
  localparam int RXS_W = $clog2(RXS_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [TXD_W-1:0] txd_free,
  input  logic [TXS_W-1:0] txs_used,
  input  logic [RXS_W-1:0] rxs_used,
  input  logic             rx_drop,
  output logic             irq
);
  logic [31:0]   lvl_q;
  logic [NB-1:0] en_q;
  logic [NB-1:0] cond_vec, rise_vec, clr_vec, stat_vec;
  logic [31:0]   rdata_q;
  logic          irq_q;
  logic          wr_lvl, wr_en_reg, wr_stat;

  assign wr_lvl    = wr_en && (addr == A_LVL);
  assign wr_en_reg = wr_en && (addr == A_EN);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign clr_vec   = wr_stat ? (wdata[NB-1:0] & IRQ_MASK) : '0;

  fli_cond #(.TXD_W(TXD_W), .TXS_DEPTH(TXS_DEPTH), .RXS_DEPTH(RXS_DEPTH)) u_cond (
    .lvl(lvl_q), .txd_free(txd_free), .txs_used(txs_used),
    .rxs_used(rxs_used), .rx_drop(rx_drop), .cond(cond_vec)
  );

  fli_sticky #(.N(NB), .MASK(IRQ_MASK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .cond(cond_vec), .clr(clr_vec),
    .rise(rise_vec), .stat(stat_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LVL_RST;
      en_q  <= '0;
    end else begin
      if (wr_lvl)    lvl_q <= wdata & LVL_WMASK;
      if (wr_en_reg) en_q  <= wdata[NB-1:0] & IRQ_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (addr)
        A_LVL:   rdata_q <= lvl_q;
        A_EN:    rdata_q <= 32'(en_q);
        A_STAT:  rdata_q <= 32'(stat_vec);
        default: rdata_q <= BYTE_PAT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_vec & en_q);
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/fli_chk.sv
module fli_chk import fli_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic [31:0]   rdata,
  input logic          rx_drop,
  input logic [NB-1:0] cond,
  input logic [NB-1:0] stat,
  input logic [NB-1:0] en,
  input logic          irq
);
  assert_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_BYTE) |=> (rdata == BYTE_PAT));
  assert_lvl_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_LVL) |=> (rdata[15:8] == 8'h00));
  assert_txda_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond[B_TXDA]) |=> stat[B_TXDA]);
  assert_full_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond[B_TXSF]) |=> stat[B_TXSF]);
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> stat[B_RXDR]);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((stat & $past(stat)) == $past(stat)));
  assert_en_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_EN) |=> ((rdata & ~32'(IRQ_MASK)) == 32'h0));
  assert_irq_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en)) |=> irq);
  assert_irq_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & en)) |=> !irq);
endmodule

bind fifo_lvl_irq fli_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rx_drop(rx_drop), .cond(cond_vec), .stat(stat_vec),
  .en(en_q), .irq(irq)
);

// File: tb/fifo_lvl_irq_test.sv
`timescale 1ns/1ps
module fifo_lvl_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] txd_free = '0;
  logic [7:0]  txs_used = '0, rxs_used = '0;
  logic        rx_drop = 1'b0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_lvl_irq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd_free(txd_free), .txs_used(txs_used),
    .rxs_used(rxs_used), .rx_drop(rx_drop), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'h0);
    rd(2'd0, d); chk("R1 threshold reset", d, 32'h4800_0000);
    rd(2'd1, d); chk("R1 enable reset", d, 32'h0);
    rd(2'd2, d); chk("R1 status reset", d, 32'h0);
  endtask

  task automatic t_pattern;
    logic [31:0] d;
    rd(2'd3, d); chk("R2 R11 pattern", d, 32'h8765_4321);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R2 pattern after write", d, 32'h8765_4321);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R3 reserved bits", d, 32'hFFFF_00FF);
    wr(2'd0, 32'h0205_0007);
    rd(2'd0, d); chk("R3 field write", d, 32'h0205_0007);
  endtask

  task automatic t_payload;
    logic [31:0] d;
    txd_free = 16'd128; step(2);
    rd(2'd2, d); chk("R4 equal does not set", d, 32'h0);
    txd_free = 16'd129; step(2);
    rd(2'd2, d); chk("R4 above sets bit 9", d, 32'h200);
    txd_free = 16'd0; step(1);
    wr(2'd2, 32'h200);
    rd(2'd2, d); chk("R8 clear bit 9", d, 32'h0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    txs_used = 8'd5; rxs_used = 8'd7; step(2);
    rd(2'd2, d); chk("R5 at threshold", d, 32'h0);
    txs_used = 8'd6; rxs_used = 8'd8; step(2);
    rd(2'd2, d); chk("R5 above threshold", d, 32'h088);
    txs_used = 8'd0; rxs_used = 8'd0; step(1);
    wr(2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_full;
    logic [31:0] d;
    txs_used = 8'd128; rxs_used = 8'd128; step(2);
    rd(2'd2, d); chk("R6 both full", d, 32'h198);
    txs_used = 8'd0; rxs_used = 8'd0; step(1);
    wr(2'd2, 32'h198);
    rd(2'd2, d); chk("R6 cleared", d, 32'h0);
  endtask

  task automatic t_drop;
    logic [31:0] d;
    rx_drop = 1'b1; step(1); rx_drop = 1'b0; step(2);
    rd(2'd2, d); chk("R7 R8 drop held", d, 32'h040);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R8 write zero no effect", d, 32'h040);
    wr(2'd2, 32'h040);
    rd(2'd2, d); chk("R8 write one clears", d, 32'h0);
  endtask

  task automatic t_rearm;
    logic [31:0] d;
    txs_used = 8'd6; step(2);
    wr(2'd2, 32'h080);
    rd(2'd2, d); chk("R9 gap after clear", d, 32'h0);
    rd(2'd2, d); chk("R9 set again", d, 32'h080);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 enable bits", d, 32'h3D8);
    step(2); chk("R10 irq enabled", 32'(irq), 32'h1);
    wr(2'd1, 32'h008); step(2);
    chk("R10 irq masked", 32'(irq), 32'h0);
    wr(2'd1, 32'h080); step(2);
    chk("R10 irq unmasked", 32'(irq), 32'h1);
    txs_used = 8'd0; step(1);
    wr(2'd2, 32'h080); step(2);
    chk("R10 irq after clear", 32'(irq), 32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_pattern();
    t_fields();
    t_payload();
    t_levels();
    t_full();
    t_drop();
    t_rearm();
    t_irq();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule